// File: doc/BRIEF.md
# Multi-Mode Inversion Flit Codec

This block sits in a network interface and lowers the energy spent on an on-chip link. For every body flit it weighs four ways to send the word against the word the link is already holding: unchanged, with the odd-indexed bits flipped, with the even-indexed bits flipped, or with every bit flipped. It sends the cheapest of the four. A 2-bit action code travels on two extra link wires beside the data, and the receiving side uses that code to flip the same bits back.

The link cost of a candidate is counted per bit and per adjacent bit pair. Every data wire that toggles costs 1. A pair in which exactly one wire toggles costs 1 more. A pair in which both wires toggle in opposite directions costs 2 more. Header flits are never encoded, because routers have to read them.

The transmit half registers the chosen word and its code onto the link. The receive half is a separate pipeline stage. It takes a link word and its code and returns the original flit. The two halves share only the bit-mask decode.

Top module: `flit_inv_codec`

## Requirements
- R1: While rst_n is low, link_valid, link_head, link_flit, link_code, out_valid, out_head and out_flit are all zero.
- R2: One clock after in_valid is sampled high, link_valid is 1 and link_head equals the sampled in_head. One clock after in_valid is sampled low, link_valid is 0.
- R3: A flit sampled with in_head = 1 goes onto link_flit unchanged, with link_code = 00.
- R4: For a body flit, the cost of the word placed on link_flit equals the lowest cost among the four candidates. The cost is taken against the link word held before that flit: 1 per toggled data bit, plus 1 per adjacent pair with exactly one toggled bit, plus 2 per adjacent pair whose bits toggle in opposite directions.
- R5: When candidates tie on cost, the first one in this order is chosen: no inversion, odd inversion, even inversion, full inversion.
- R6: The codes and masks are: 00 flips no bit; 10 flips bits 1, 3, 5, …; 01 flips bits 0, 2, 4, …; 11 flips every bit. A body flit appears as link_flit = in_flit XOR mask(link_code).
- R7: The reference word is the last word driven onto link_flit, headers included. It is zero after reset. While in_valid is low, link_flit and link_code keep their values.
- R8: One clock after rx_valid is sampled high, out_valid is 1, out_head equals rx_head and out_flit equals rx_flit XOR mask(rx_code). One clock after rx_valid is sampled low, out_valid is 0.
- R9: When link_* is looped back to rx_*, out_flit two clocks after a flit is accepted equals that flit, for both header and body flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A flit is offered this cycle |
| in_head | input | 1 | Offered flit is a header |
| in_flit | input | W | Offered flit payload |
| link_valid | output | 1 | Link word valid |
| link_head | output | 1 | Link word is a header |
| link_flit | output | W | Encoded word on the link |
| link_code | output | 2 | Action code sent with the link word |
| rx_valid | input | 1 | Received link word valid |
| rx_head | input | 1 | Received word is a header |
| rx_flit | input | W | Received encoded word |
| rx_code | input | 2 | Received action code |
| out_valid | output | 1 | Decoded flit valid |
| out_head | output | 1 | Decoded flit is a header |
| out_flit | output | W | Decoded flit |

## Verification
The stimulus mixes several kinds of flits. All-ones and all-zeros words after an opposite reference favour full inversion. Alternating 0x55/0xAA patterns separate odd inversion from even inversion. Words equal to the current reference must select no action. A first body flit of 0xF0 against the zero reset reference makes no inversion and full inversion tie, which checks the tie order.

Headers placed between body flits check two things: that headers bypass encoding, and that a header updates the reference. For every flit the cost of the chosen word is compared with a minimum computed by the bench's own arithmetic. The loopback then confirms that each flit is recovered.

// File: rtl/flit_inv_pkg.sv
package flit_inv_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_EVEN = 2'b01,
    ACT_ODD  = 2'b10,
    ACT_FULL = 2'b11
  } act_e;

  localparam int NUM_CAND = 4;

  // candidate index order doubles as tie priority
  function automatic logic [1:0] cand_code(input int idx);
    case (idx)
      0:       return ACT_NONE;
      1:       return ACT_ODD;
      2:       return ACT_EVEN;
      default: return ACT_FULL;
    endcase
  endfunction
endpackage

// File: rtl/flit_inv_mask.sv
module flit_inv_mask #(
  parameter int W = 32
) (
  input  logic [1:0]   code,
  output logic [W-1:0] mask
);
  // code bit 1 selects odd positions, bit 0 selects even positions
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i % 2 == 1) begin : g_odd
      assign mask[i] = code[1];
    end else begin : g_even
      assign mask[i] = code[0];
    end
  end
endmodule

// File: rtl/flit_inv_cost.sv
module flit_inv_cost #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic [W-1:0]  prev,
  input  logic [W-1:0]  cand,
  output logic [CW-1:0] cost
);
  logic [W-1:0] tog;
  logic [W-1:0] one_side;
  logic [W-1:0] opposite;

  assign tog = prev ^ cand;

  for (genvar i = 0; i < W; i++) begin : g_pair
    if (i < W - 1) begin : g_real
      assign one_side[i] = tog[i] ^ tog[i+1];
      assign opposite[i] = tog[i] & tog[i+1] & (cand[i] ^ cand[i+1]);
    end else begin : g_pad
      assign one_side[i] = 1'b0;
      assign opposite[i] = 1'b0;
    end
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < W; i++) begin
      cost = cost + CW'(tog[i]) + CW'(one_side[i]) + (CW'(opposite[i]) << 1);
    end
  end
endmodule

// File: rtl/flit_inv_chooser.sv
module flit_inv_chooser
  import flit_inv_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [NUM_CAND-1:0][CW-1:0] costs,
  output logic [1:0]                  code,
  output logic [CW-1:0]               best
);
  logic [1:0] sel;

  always_comb begin
    best = costs[0];
    sel  = 2'd0;
    for (int k = 1; k < NUM_CAND; k++) begin
      if (costs[k] < best) begin
        best = costs[k];
        sel  = 2'(k);
      end
    end
    code = cand_code(int'(sel));
  end
endmodule

// File: rtl/flit_inv_decoder.sv
module flit_inv_decoder #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic         rx_head,
  input  logic [W-1:0] rx_flit,
  input  logic [1:0]   rx_code,
  output logic         out_valid,
  output logic         out_head,
  output logic [W-1:0] out_flit
);
  logic [W-1:0] undo_mask;

  flit_inv_mask #(.W(W)) u_mask (.code(rx_code), .mask(undo_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_head  <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= rx_valid;
      if (rx_valid) begin
        out_head <= rx_head;
        out_flit <= rx_flit ^ undo_mask;
      end
    end
  end
endmodule

// File: rtl/flit_inv_codec.sv
module flit_inv_codec
  import flit_inv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_head,
  input  logic [W-1:0] in_flit,
  output logic         link_valid,
  output logic         link_head,
  output logic [W-1:0] link_flit,
  output logic [1:0]   link_code,
  input  logic         rx_valid,
  input  logic         rx_head,
  input  logic [W-1:0] rx_flit,
  input  logic [1:0]   rx_code,
  output logic         out_valid,
  output logic         out_head,
  output logic [W-1:0] out_flit
);
  localparam int CW = $clog2(3 * W);

  logic [NUM_CAND-1:0][CW-1:0] cost_vec;
  logic [NUM_CAND-1:0][W-1:0]  cand_vec;
  logic [1:0]                  pick_code;
  logic [CW-1:0]               pick_cost;
  logic [W-1:0]                pick_mask;
  logic [W-1:0]                tx_word;
  logic [1:0]                  tx_code;

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    localparam logic [1:0] KCODE = cand_code(k);
    logic [W-1:0] cmask;
    flit_inv_mask #(.W(W)) u_mask (.code(KCODE), .mask(cmask));
    assign cand_vec[k] = in_flit ^ cmask;
    flit_inv_cost #(.W(W), .CW(CW)) u_cost (
      .prev(link_flit), .cand(cand_vec[k]), .cost(cost_vec[k])
    );
  end

  flit_inv_chooser #(.CW(CW)) u_choose (
    .costs(cost_vec), .code(pick_code), .best(pick_cost)
  );

  flit_inv_mask #(.W(W)) u_pick_mask (.code(pick_code), .mask(pick_mask));

  assign tx_code = in_head ? ACT_NONE : pick_code;
  assign tx_word = in_head ? in_flit : (in_flit ^ pick_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_head  <= 1'b0;
      link_flit  <= '0;
      link_code  <= ACT_NONE;
    end else begin
      link_valid <= in_valid;
      if (in_valid) begin
        link_head <= in_head;
        link_flit <= tx_word;
        link_code <= tx_code;
      end
    end
  end

  flit_inv_decoder #(.W(W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_head(rx_head), .rx_flit(rx_flit), .rx_code(rx_code),
    .out_valid(out_valid), .out_head(out_head), .out_flit(out_flit)
  );
endmodule

// File: rtl/flit_inv_codec_chk.sv
module flit_inv_codec_chk #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_head,
  input logic [W-1:0]         in_flit,
  input logic                 link_valid,
  input logic [W-1:0]         link_flit,
  input logic [1:0]           link_code,
  input logic                 rx_valid,
  input logic [1:0]           rx_code,
  input logic [W-1:0]         rx_flit,
  input logic                 out_valid,
  input logic [W-1:0]         out_flit,
  input logic [3:0][CW-1:0]   cost_vec,
  input logic [CW-1:0]        pick_cost
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> link_valid);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!link_valid && $stable(link_flit) && $stable(link_code)));

  a_r3_header_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head) |=> (link_code == 2'b00 && link_flit == $past(in_flit)));

  a_r4_no_worse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_head) |-> (pick_cost <= cost_vec[0] && pick_cost <= cost_vec[1]
                                && pick_cost <= cost_vec[2] && pick_cost <= cost_vec[3]));

  a_r8_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_code == 2'b00) |=> (out_valid && out_flit == $past(rx_flit)));

  a_r8_full_undo: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_code == 2'b11) |=> (out_valid && out_flit == ~$past(rx_flit)));
endmodule

bind flit_inv_codec flit_inv_codec_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_head(in_head), .in_flit(in_flit),
  .link_valid(link_valid), .link_flit(link_flit), .link_code(link_code),
  .rx_valid(rx_valid), .rx_code(rx_code), .rx_flit(rx_flit),
  .out_valid(out_valid), .out_flit(out_flit),
  .cost_vec(cost_vec), .pick_cost(pick_cost)
);

// File: tb/flit_inv_codec_bench.sv
module flit_inv_codec_bench;
  localparam int W = 8;
  localparam int NV = 14;
  // {head, flit}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h3C}, {1'b0, 8'hC3}, {1'b0, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'hFF}, {1'b0, 8'h55}, {1'b0, 8'hAA}, {1'b0, 8'h0F},
    {1'b0, 8'h96}, {1'b0, 8'h69}, {1'b0, 8'h81}, {1'b0, 8'h7E},
    {1'b1, 8'h12}, {1'b0, 8'hE7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_head = 1'b0;
  logic [W-1:0] in_flit = '0;
  logic link_valid, link_head, out_valid, out_head;
  logic [W-1:0] link_flit, out_flit;
  logic [1:0] link_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] bref = '0;

  always #4 clk = ~clk;

  flit_inv_codec #(.W(W)) u_flit_inv_codec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_head(in_head), .in_flit(in_flit),
    .link_valid(link_valid), .link_head(link_head), .link_flit(link_flit), .link_code(link_code),
    .rx_valid(link_valid), .rx_head(link_head), .rx_flit(link_flit), .rx_code(link_code),
    .out_valid(out_valid), .out_head(out_head), .out_flit(out_flit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bcost(input logic [W-1:0] p, input logic [W-1:0] c);
    int s, da, db, dd;
    s = 0;
    for (int i = 0; i < W; i++) begin
      da = int'(c[i]) - int'(p[i]);
      s += (da < 0) ? -da : da;
      if (i < W - 1) begin
        db = int'(c[i+1]) - int'(p[i+1]);
        dd = da - db;
        s += (dd < 0) ? -dd : dd;
      end
    end
    return s;
  endfunction

  function automatic logic [W-1:0] bmask(input logic [1:0] code);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++)
      m[i] = (code == 2'b11) || (code == 2'b10 && i % 2 == 1) || (code == 2'b01 && i % 2 == 0);
    return m;
  endfunction

  // called at a negedge; returns at a negedge two cycles later
  task automatic send(input logic hd, input logic [W-1:0] f);
    logic [1:0] ec, order [4];
    logic [W-1:0] ew, held;
    int best, c;
    order = '{2'b00, 2'b10, 2'b01, 2'b11};
    if (hd) begin
      ec = 2'b00; ew = f; best = bcost(bref, f);
    end else begin
      ec = 2'b00; best = bcost(bref, f);
      for (int k = 1; k < 4; k++) begin
        c = bcost(bref, f ^ bmask(order[k]));
        if (c < best) begin best = c; ec = order[k]; end
      end
      ew = f ^ bmask(ec);
    end
    in_valid = 1'b1; in_head = hd; in_flit = f;
    @(negedge clk);
    check(link_valid == 1'b1 && link_head == hd, "R2", {link_valid, link_head}, {1'b1, hd});
    if (hd) check(link_code == 2'b00 && link_flit == f, "R3", {link_code, link_flit}, {2'b00, f});
    check(link_code == ec, "R5 code choice", link_code, ec);
    check(link_flit == ew, "R6 mask", link_flit, ew);
    if (!hd) check(bcost(bref, link_flit) == best, "R4 min cost", bcost(bref, link_flit), best);
    held = link_flit;
    bref = ew;
    in_valid = 1'b0;
    @(negedge clk);
    check(link_valid == 1'b0 && link_flit == held, "R7 idle hold", link_flit, held);
    check(out_valid == 1'b1 && out_head == hd, "R8", {out_valid, out_head}, {1'b1, hd});
    check(out_flit == f, "R9 round trip", out_flit, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(link_valid == 0 && link_head == 0 && link_flit == 0 && link_code == 0, "R1 link", link_flit, 0);
    check(out_valid == 0 && out_head == 0 && out_flit == 0, "R1 out", out_flit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 / R7: zero reference, 0xF0 ties none and full at cost 5 -> none wins
    send(1'b0, 8'hF0);
    check(bref == 8'hF0, "R5 tie keeps none", bref, 8'hF0);
    // vector table
    for (int v = 0; v < NV; v++) send(VEC[v][8], VEC[v][7:0]);
    // R7: header updates reference; identical body then costs zero with no action
    send(1'b1, 8'h5A);
    send(1'b0, 8'h5A);
    check(link_code == 2'b00, "R7 header is reference", link_code, 2'b00);
    // R4: complement of reference -> full inversion
    send(1'b0, 8'hA5);
    check(link_code == 2'b11 && link_flit == 8'h5A, "R4 full pick", link_code, 2'b11);
    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(link_flit == 0 && link_code == 0 && out_valid == 0, "R1 re-reset", link_flit, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule